// File: doc/BRIEF.md
# Block Address Translation Matcher

The block holds two banks of block-translation register pairs: one bank serves instruction fetches and the other serves loads and stores. Each pair has an upper word and a lower word. The upper word describes a naturally aligned effective block, whose size is a power of two from 128 KiB to 256 MiB. It also carries separate enables for supervisor and user accesses. The lower word gives the real block base and a two-bit protection code.

A lookup is purely combinational. It takes an effective address, an instruction-fetch flag and a user-mode flag, and in the same cycle returns whether an entry matched, the translated real page address and the read, write and execute rights. Software programs the register words through a single-word write port. A write takes effect for lookups from the next clock cycle.

When more than one entry matches, the entry with the lowest index decides the result. On a miss, all outputs other than `hit` are zero, so that the surrounding logic can fall back to page-table translation.

Top module: `bat_match`

## Requirements
- R1: After reset every register word in both banks is zero, so no lookup hits until an entry is programmed.
- R2: When `wr_en` is high at a rising clock edge, `wr_data` is stored in the bank chosen by `wr_inst` (1 selects the instruction bank, 0 the data bank). The entry is chosen by `wr_idx`, and the word by `wr_lower` (1 selects the lower word, 0 the upper word). Lookups see the new value from that edge onward.
- R3: A lookup with `lk_ifetch`=1 searches only the instruction bank. A lookup with `lk_ifetch`=0 searches only the data bank.
- R4: An entry can take part only if its upper-word bit 1 is set for a supervisor lookup (`lk_user`=0), or its bit 0 is set for a user lookup (`lk_user`=1).
- R5: The upper word holds the block effective index in bits 31:17 and the length code in bits 12:2. The compare mask has bits 31:28 set and bits 27:17 equal to the inverse of length bits 12:2. All mask bits below 17 are clear. An enabled entry hits when the effective address ANDed with the mask equals upper bits 31:17 followed by 17 zero bits. An effective-index bit that the mask clears therefore prevents any hit.
- R6: On a hit, `ra_page` is the lower word ANDed with the mask, ORed with the effective address ANDed with the inverted mask, and then bits 11:0 are cleared.
- R7: The protection code is in lower-word bits 1:0. Code 0 grants no rights. Code 2 grants read, write and execute. Codes 1 and 3 grant read and execute only.
- R8: When several enabled entries match, the one with the lowest index supplies the address and the rights.
- R9: On a miss, `hit`, `ra_page`, `perm_r`, `perm_w` and `perm_x` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_inst | input | 1 | Write bank select: 1 instruction, 0 data |
| wr_idx | input | IDXW | Entry index to write |
| wr_lower | input | 1 | Word select: 1 lower, 0 upper |
| wr_data | input | 32 | Word to store |
| lk_ea | input | 32 | Effective address to look up |
| lk_ifetch | input | 1 | Lookup is an instruction fetch |
| lk_user | input | 1 | Lookup is in user mode |
| hit | output | 1 | An enabled entry matched |
| ra_page | output | 32 | Translated real page address |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |

## Verification
The assertions rely on one property of the inputs: the lookup inputs and the register contents are settled well before the sampling edge, because the result is combinational. The bench keeps to this by driving every input on the falling edge and sampling shortly afterwards. The assertions also rely on the block's minimum size of 128 KiB, which means the page-offset bits 16:12 of a hit always come straight from the effective address. This holds for every encoding, so the stimulus can place any value in the length field, including codes whose index bits fall under the mask.

// File: rtl/bat_match.sv
module bat_match #(
  parameter int NENT = 4,
  localparam int IDXW = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_inst,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_lower,
  input  logic [31:0]     wr_data,
  input  logic [31:0]     lk_ea,
  input  logic            lk_ifetch,
  input  logic            lk_user,
  output logic            hit,
  output logic [31:0]     ra_page,
  output logic            perm_r,
  output logic            perm_w,
  output logic            perm_x
);

  logic [31:0] iu [NENT];
  logic [31:0] il [NENT];
  logic [31:0] du [NENT];
  logic [31:0] dl [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        iu[i] <= '0;
        il[i] <= '0;
        du[i] <= '0;
        dl[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NENT; i++) begin
        if (wr_idx == IDXW'(i)) begin
          if (wr_inst && !wr_lower)  iu[i] <= wr_data;
          if (wr_inst && wr_lower)   il[i] <= wr_data;
          if (!wr_inst && !wr_lower) du[i] <= wr_data;
          if (!wr_inst && wr_lower)  dl[i] <= wr_data;
        end
      end
    end
  end

  logic [NENT-1:0] match;
  logic [31:0]     ra_e [NENT];
  logic [1:0]      pp_e [NENT];

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    wire [31:0] up   = lk_ifetch ? iu[g] : du[g];
    wire [31:0] lo   = lk_ifetch ? il[g] : dl[g];
    wire        en   = lk_user ? up[0] : up[1];
    wire [31:0] mask = {4'hF, ~up[12:2], 17'd0};
    assign match[g] = en && ((lk_ea & mask) == {up[31:17], 17'd0});
    assign ra_e[g]  = ((lo & mask) | (lk_ea & ~mask)) & 32'hFFFF_F000;
    assign pp_e[g]  = lo[1:0];
  end

  always_comb begin
    hit     = 1'b0;
    ra_page = '0;
    perm_r  = 1'b0;
    perm_w  = 1'b0;
    perm_x  = 1'b0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        ra_page = ra_e[i];
        perm_r  = (pp_e[i] != 2'd0);
        perm_x  = (pp_e[i] != 2'd0);
        perm_w  = (pp_e[i] == 2'd2);
      end
    end
  end

endmodule

module bat_match_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] lk_ea,
  input logic        hit,
  input logic [31:0] ra_page,
  input logic        perm_r,
  input logic        perm_w,
  input logic        perm_x
);

  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (ra_page == 32'd0) && !perm_r && !perm_w && !perm_x);

  p_page_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ra_page[11:0] == 12'd0);

  p_offset_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ra_page[16:12] == lk_ea[16:12]);

  p_write_needs_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    perm_w |-> perm_r && perm_x);

  p_read_exec_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    perm_r == perm_x);

endmodule

bind bat_match bat_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_ea(lk_ea), .hit(hit), .ra_page(ra_page),
  .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
);

// File: tb/sim_bat_match.sv
module sim_bat_match;
  localparam int NENT = 4;
  localparam int IDXW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_inst = 1'b0, wr_lower = 1'b0;
  logic [IDXW-1:0] wr_idx = '0;
  logic [31:0] wr_data = '0, lk_ea = '0;
  logic lk_ifetch = 1'b0, lk_user = 1'b0;
  logic hit, perm_r, perm_w, perm_x;
  logic [31:0] ra_page;

  int n_chk = 0, n_bad = 0;
  logic [31:0] su [2][NENT];
  logic [31:0] sl [2][NENT];

  always #2 clk = ~clk;

  bat_match #(.NENT(NENT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_inst(wr_inst), .wr_idx(wr_idx),
    .wr_lower(wr_lower), .wr_data(wr_data), .lk_ea(lk_ea), .lk_ifetch(lk_ifetch),
    .lk_user(lk_user), .hit(hit), .ra_page(ra_page), .perm_r(perm_r),
    .perm_w(perm_w), .perm_x(perm_x)
  );

  task automatic put(input logic side, input int idx, input logic lower, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_inst = side; wr_idx = IDXW'(idx); wr_lower = lower; wr_data = d;
    if (lower) sl[side][idx] = d; else su[side][idx] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_at(input logic [31:0] ea, input logic ifl, input logic usr,
                           input logic eh, input logic [31:0] era,
                           input logic er, input logic ew, input logic ex,
                           input string tag);
    @(negedge clk);
    lk_ea = ea; lk_ifetch = ifl; lk_user = usr;
    #1;
    n_chk++;
    if (hit !== eh || ra_page !== era || perm_r !== er || perm_w !== ew || perm_x !== ex) begin
      n_bad++;
      $display("FAIL %s ea=%h if=%0b u=%0b got hit=%0b ra=%h rwx=%0b%0b%0b exp hit=%0b ra=%h rwx=%0b%0b%0b",
               tag, ea, ifl, usr, hit, ra_page, perm_r, perm_w, perm_x, eh, era, er, ew, ex);
    end
  endtask

  task automatic model(input logic [31:0] ea, input logic ifl, input logic usr,
                       output logic eh, output logic [31:0] era,
                       output logic er, output logic ew, output logic ex);
    eh = 1'b0; era = '0; er = 1'b0; ew = 1'b0; ex = 1'b0;
    for (int i = 0; i < NENT; i++) begin
      logic [31:0] u, l, m;
      u = su[ifl][i]; l = sl[ifl][i];
      m = 32'hFFFE_0000 & ~({19'd0, u[12:2], 2'd0} << 15);
      if (!eh && (usr ? u[0] : u[1]) && ((ea & m) == (u & 32'hFFFE_0000))) begin
        eh = 1'b1;
        era = ((l & m) | (ea & ~m)) & 32'hFFFF_F000;
        er = (l[1:0] != 2'd0); ex = er; ew = (l[1:0] == 2'd2);
      end
    end
  endtask

  initial begin
    logic eh, er, ew, ex;
    logic [31:0] era;
    logic [31:0] offs [7];
    offs = '{32'h0000000, 32'h0001234, 32'h001FFFF, 32'h0020ABC,
             32'h01FFFFF, 32'h0200000, 32'h0FFFFFF};
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < NENT; i++) begin su[s][i] = '0; sl[s][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    expect_at(32'h1001_2345, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, "R1");
    expect_at(32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, "R1");

    put(1'b0, 0, 1'b0, 32'h1000_0002); put(1'b0, 0, 1'b1, 32'h8000_0002);
    put(1'b0, 1, 1'b0, 32'h2000_1FFF); put(1'b0, 1, 1'b1, 32'h4000_0001);
    put(1'b0, 2, 1'b0, 32'h1000_003F); put(1'b0, 2, 1'b1, 32'hC000_0003);
    put(1'b0, 3, 1'b0, 32'h3000_0005); put(1'b0, 3, 1'b1, 32'h7000_0000);
    put(1'b1, 0, 1'b0, 32'h2000_0003); put(1'b1, 0, 1'b1, 32'h0002_0002);
    put(1'b1, 1, 1'b0, 32'h5002_0006); put(1'b1, 1, 1'b1, 32'h9000_0002);

    expect_at(32'h1001_2345, 1'b0, 1'b0, 1'b1, 32'h8001_2000, 1'b1, 1'b1, 1'b1, "R8");
    expect_at(32'h1001_2345, 1'b0, 1'b1, 1'b1, 32'hC001_2000, 1'b1, 1'b0, 1'b1, "R4");
    expect_at(32'h3001_0000, 1'b0, 1'b1, 1'b1, 32'h7001_0000, 1'b0, 1'b0, 1'b0, "R7");
    expect_at(32'h3001_0000, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, "R4");
    expect_at(32'h1001_2345, 1'b1, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, "R3");
    expect_at(32'h2000_5678, 1'b1, 1'b0, 1'b1, 32'h0002_5000, 1'b1, 1'b1, 1'b1, "R3");
    expect_at(32'h2000_5678, 1'b0, 1'b0, 1'b1, 32'h4000_5000, 1'b1, 1'b0, 1'b1, "R6");
    expect_at(32'h5002_0000, 1'b1, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, "R5");
    expect_at(32'h0000_1000, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, "R9");

    for (int hi = 0; hi < 16; hi++)
      for (int k = 0; k < 7; k++)
        for (int md = 0; md < 4; md++) begin
          logic [31:0] ea;
          ea = {hi[3:0], 28'd0} | offs[k];
          model(ea, md[1], md[0], eh, era, er, ew, ex);
          expect_at(ea, md[1], md[0], eh, era, er, ew, ex, "R5/R6 sweep");
        end

    put(1'b0, 0, 1'b1, 32'h8000_0000);
    expect_at(32'h1001_2345, 1'b0, 1'b0, 1'b1, 32'h8001_2000, 1'b0, 1'b0, 1'b0, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule